// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the transmit half of a scatter-gather DMA channel. It follows a linked list of descriptors held in memory and sends each descriptor's data buffer out as a byte stream. A kick pulse starts it, but only while the channel is running and not idle. It first loads the current pointer. For each descriptor it reads the descriptor words through a simple word read/write memory port, then reads the data buffer one word at a time and sends each word as one stream beat. When the buffer is done it writes a completion status back into the descriptor. It then moves on to the descriptor named by the next-descriptor field.

The walk stops in one of two ways. It stops when the descriptor it just wrote back is the tail pointer. It also stops when a freshly fetched descriptor already carries the complete flag, and in that case it moves no data. Either way it raises a one-cycle set-idle request for the channel status logic. Each write-back gives one completion pulse for the interrupt coalescing logic, plus a pointer update carrying the new current pointer. The application words of the frame's first descriptor are held on an output for the receiver of the frame.

Top module: `sgw_walker`

## Requirements
- R1: After reset, no memory request, stream beat, completion pulse, pointer update or set-idle request is given.
- R2: A kick is ignored, and no memory access follows, unless run is high and idle is low in the kick cycle.
- R3: A descriptor at byte address D holds these fields. Buffer address low word at D+0x00. Next pointer low word at D+0x08. Control at D+0x10. Status at D+0x14. Application words at D+0x18 onward. Control bits 22:0 hold the byte length, bit 27 marks start of frame and bit 26 marks end of frame. Status bit 31 is the complete flag. Buffer addresses are multiples of 4.
- R4: If the fetched status already has bit 31 set, the engine gives a set-idle request and stops. It sends no beats, gives no completion pulse and makes no write.
- R5: The buffer goes out one 32-bit word per beat, and the byte at the lowest address is in bits 7:0. While valid is high and ready is low, data, keep and last hold steady.
- R6: Every beat has keep 4'b1111 except the last beat of a descriptor. That beat has keep 4'b0001, 4'b0011 or 4'b0111 when the length mod 4 is 1, 2 or 3.
- R7: Last is high only on the final beat of a descriptor whose control bit 26 is set.
- R8: After the transfer, the status word at D+0x14 is written with the byte length in bits 22:0 and bit 31 set.
- R9: Each write-back gives exactly one completion pulse together with a pointer update. The pointer output then carries the descriptor's next pointer.
- R10: If the descriptor just written back equals the tail pointer, a set-idle request is given in the same cycle as its completion pulse, and the walk stops. Otherwise the walk goes on to the next descriptor.
- R11: The application output is loaded only from a descriptor with control bit 27 set. Other descriptors leave it unchanged.
- R12: A descriptor of length 0 sends no beats and is written back with status 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Channel is running |
| idle_i | input | 1 | Channel is idle |
| kick_i | input | 1 | Start pulse (tail pointer written) |
| cur_ptr_i | input | ADDR_W | First descriptor to process |
| tail_ptr_i | input | ADDR_W | Last descriptor of the chain |
| cur_ptr_o | output | ADDR_W | Updated current pointer |
| cur_ptr_we_o | output | 1 | Pulse: cur_ptr_o carries a new pointer |
| done_o | output | 1 | Pulse: one descriptor completed |
| set_idle_o | output | 1 | Pulse: request the channel to go idle |
| app_o | output | 32*NUM_APP | Application words of the frame's first descriptor |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| m_tdata_o | output | 32 | Stream data |
| m_tkeep_o | output | 4 | Stream byte enables |
| m_tlast_o | output | 1 | Stream end of frame |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready |

## Verification
Completion and the stop at the tail both happen when the tail descriptor is written back, so the completion pulse and the set-idle request must come out in the same cycle. The bench builds chains whose last descriptor is the tail pointer, and a chain whose tail is the first of two linked descriptors. It counts the cycles in which both pulses are high and checks that exactly one such cycle appears per walk. It then checks that the descriptor after the tail is left untouched in memory. The stream is stalled with a toggling ready during a multi-descriptor frame, so that stalls fall on the short last beats and on the frame's final beat.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STAT,
    ST_CTRL,
    ST_BUF,
    ST_NEXT,
    ST_APP,
    ST_DATA,
    ST_SEND,
    ST_WB
  } sgw_state_e;

  // descriptor byte offsets
  localparam int unsigned OFF_BUF  = 0;
  localparam int unsigned OFF_NEXT = 8;
  localparam int unsigned OFF_CTRL = 16;
  localparam int unsigned OFF_STAT = 20;
  localparam int unsigned OFF_APP  = 24;

  // control / status bit positions
  localparam int unsigned LEN_W    = 23;
  localparam int unsigned BIT_EOF  = 26;
  localparam int unsigned BIT_SOF  = 27;
  localparam int unsigned BIT_CMPL = 31;

endpackage

// File: rtl/sgw_keep_gen.sv
module sgw_keep_gen #(
  parameter int unsigned LW = 23,
  parameter int unsigned BYTES = 4
) (
  input  logic [LW-1:0]    rem_i,
  output logic [BYTES-1:0] keep_o,
  output logic             last_o
);
  // byte lane i is live while more than i bytes remain
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign keep_o[i] = (rem_i > LW'(i));
  end
  assign last_o = (rem_i <= LW'(BYTES));
endmodule

// File: rtl/sgw_desc_hold.sv
module sgw_desc_hold
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_APP = 5,
  localparam int unsigned AIW    = (NUM_APP > 1) ? $clog2(NUM_APP) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_ctrl_i,
  input  logic                  cap_next_i,
  input  logic                  cap_app_i,
  input  logic [AIW-1:0]        app_idx_i,
  input  logic [31:0]           word_i,
  output logic [LEN_W-1:0]      len_o,
  output logic                  sof_o,
  output logic                  eof_o,
  output logic [ADDR_W-1:0]     next_o,
  output logic [32*NUM_APP-1:0] app_o
);
  logic [LEN_W-1:0]  len_q;
  logic              sof_q, eof_q;
  logic [ADDR_W-1:0] next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      sof_q <= 1'b0;
      eof_q <= 1'b0;
    end else if (cap_ctrl_i) begin
      len_q <= word_i[LEN_W-1:0];
      sof_q <= word_i[BIT_SOF];
      eof_q <= word_i[BIT_EOF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          next_q <= '0;
    else if (cap_next_i) next_q <= word_i[ADDR_W-1:0];
  end

  for (genvar g = 0; g < NUM_APP; g++) begin : g_app
    logic [31:0] app_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  app_q <= '0;
      else if (cap_app_i && app_idx_i == AIW'(g))  app_q <= word_i;
    end
    assign app_o[g*32 +: 32] = app_q;
  end

  assign len_o  = len_q;
  assign sof_o  = sof_q;
  assign eof_o  = eof_q;
  assign next_o = next_q;
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_APP = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic                  idle_i,
  input  logic                  kick_i,
  input  logic [ADDR_W-1:0]     cur_ptr_i,
  input  logic [ADDR_W-1:0]     tail_ptr_i,
  output logic [ADDR_W-1:0]     cur_ptr_o,
  output logic                  cur_ptr_we_o,
  output logic                  done_o,
  output logic                  set_idle_o,
  output logic [32*NUM_APP-1:0] app_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [31:0]           mem_wdata_o,
  input  logic [31:0]           mem_rdata_i,
  input  logic                  mem_ack_i,
  output logic [31:0]           m_tdata_o,
  output logic [3:0]            m_tkeep_o,
  output logic                  m_tlast_o,
  output logic                  m_tvalid_o,
  input  logic                  m_tready_i
);
  localparam int unsigned AIW = (NUM_APP > 1) ? $clog2(NUM_APP) : 1;
  localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'(OFF_BUF);
  localparam logic [ADDR_W-1:0] A_NEXT = ADDR_W'(OFF_NEXT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_APP  = ADDR_W'(OFF_APP);

  sgw_state_e        st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, baddr_q, baddr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [AIW-1:0]    aidx_q, aidx_d;
  logic [31:0]       word_q, word_d;
  logic              done_q, done_d, idle_q, idle_d, pwe_q, pwe_d;
  logic              cap_ctrl, cap_next, cap_app, go;
  logic [LEN_W-1:0]  len;
  logic              sof, eof, kg_last;
  logic [3:0]        kg_keep;
  logic [ADDR_W-1:0] next_ptr;

  sgw_desc_hold #(.ADDR_W(ADDR_W), .NUM_APP(NUM_APP)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .cap_ctrl_i(cap_ctrl), .cap_next_i(cap_next), .cap_app_i(cap_app),
    .app_idx_i(aidx_q), .word_i(mem_rdata_i),
    .len_o(len), .sof_o(sof), .eof_o(eof), .next_o(next_ptr), .app_o(app_o)
  );

  sgw_keep_gen #(.LW(LEN_W), .BYTES(4)) u_keep (
    .rem_i(rem_q), .keep_o(kg_keep), .last_o(kg_last)
  );

  assign go = run_i && !idle_i;

  always_comb begin
    st_d = st_q;  ptr_d = ptr_q;  baddr_d = baddr_q;  rem_d = rem_q;
    aidx_d = aidx_q;  word_d = word_q;
    done_d = 1'b0;  idle_d = 1'b0;  pwe_d = 1'b0;
    cap_ctrl = 1'b0;  cap_next = 1'b0;  cap_app = 1'b0;
    mem_req_o = 1'b0;  mem_we_o = 1'b0;  mem_addr_o = ptr_q;  mem_wdata_o = '0;
    unique case (st_q)
      ST_IDLE: if (kick_i && go) begin
        ptr_d = cur_ptr_i;
        st_d  = ST_STAT;
      end
      ST_STAT: begin
        mem_req_o = 1'b1;  mem_addr_o = ptr_q + A_STAT;
        if (mem_ack_i) begin
          if (mem_rdata_i[BIT_CMPL]) begin
            idle_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = ST_CTRL;
          end
        end
      end
      ST_CTRL: begin
        mem_req_o = 1'b1;  mem_addr_o = ptr_q + A_CTRL;
        if (mem_ack_i) begin
          cap_ctrl = 1'b1;
          rem_d    = mem_rdata_i[LEN_W-1:0];
          st_d     = ST_BUF;
        end
      end
      ST_BUF: begin
        mem_req_o = 1'b1;  mem_addr_o = ptr_q + A_BUF;
        if (mem_ack_i) begin
          baddr_d = mem_rdata_i[ADDR_W-1:0];
          st_d    = ST_NEXT;
        end
      end
      ST_NEXT: begin
        mem_req_o = 1'b1;  mem_addr_o = ptr_q + A_NEXT;
        if (mem_ack_i) begin
          cap_next = 1'b1;
          aidx_d   = '0;
          if (sof)              st_d = ST_APP;
          else if (rem_q == '0) st_d = ST_WB;
          else                  st_d = ST_DATA;
        end
      end
      ST_APP: begin
        mem_req_o = 1'b1;
        mem_addr_o = ptr_q + A_APP + (ADDR_W'(aidx_q) << 2);
        if (mem_ack_i) begin
          cap_app = 1'b1;
          if (aidx_q == AIW'(NUM_APP - 1)) st_d = (rem_q == '0) ? ST_WB : ST_DATA;
          else                             aidx_d = aidx_q + 1'b1;
        end
      end
      ST_DATA: begin
        mem_req_o = 1'b1;  mem_addr_o = baddr_q;
        if (mem_ack_i) begin
          word_d = mem_rdata_i;
          st_d   = ST_SEND;
        end
      end
      ST_SEND: if (m_tready_i) begin
        baddr_d = baddr_q + ADDR_W'(4);
        if (kg_last) begin
          rem_d = '0;
          st_d  = ST_WB;
        end else begin
          rem_d = rem_q - LEN_W'(4);
          st_d  = ST_DATA;
        end
      end
      ST_WB: begin
        mem_req_o   = 1'b1;  mem_we_o = 1'b1;  mem_addr_o = ptr_q + A_STAT;
        mem_wdata_o = 32'(len) | (32'h1 << BIT_CMPL);
        if (mem_ack_i) begin
          done_d = 1'b1;
          pwe_d  = 1'b1;
          ptr_d  = next_ptr;
          if (ptr_q == tail_ptr_i) begin
            idle_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = go ? ST_STAT : ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ptr_q <= '0;  baddr_q <= '0;  rem_q <= '0;
      aidx_q <= '0;  word_q <= '0;
      done_q <= 1'b0;  idle_q <= 1'b0;  pwe_q <= 1'b0;
    end else begin
      st_q <= st_d;  ptr_q <= ptr_d;  baddr_q <= baddr_d;  rem_q <= rem_d;
      aidx_q <= aidx_d;  word_q <= word_d;
      done_q <= done_d;  idle_q <= idle_d;  pwe_q <= pwe_d;
    end
  end

  assign cur_ptr_o    = ptr_q;
  assign cur_ptr_we_o = pwe_q;
  assign done_o       = done_q;
  assign set_idle_o   = idle_q;
  assign m_tvalid_o   = (st_q == ST_SEND);
  assign m_tdata_o    = word_q;
  assign m_tkeep_o    = kg_keep;
  assign m_tlast_o    = eof && kg_last;

  assert_kick_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !go) |=> !mem_req_o);
  assert_cmpl_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STAT && mem_ack_i && mem_rdata_i[BIT_CMPL]) |=> (set_idle_o && !m_tvalid_o && !done_o));
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tkeep_o) && $stable(m_tlast_o)));
  assert_keep_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid_o |-> (m_tkeep_o == 4'b0001 || m_tkeep_o == 4'b0011 || m_tkeep_o == 4'b0111 || m_tkeep_o == 4'b1111));
  assert_last_then_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid_o && m_tready_i && m_tlast_o) |=> (!m_tvalid_o && mem_we_o));
  assert_wb_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[BIT_CMPL] && mem_wdata_o[30:LEN_W] == '0));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cur_ptr_we_o && $past(mem_ack_i && mem_we_o)) ##1 !done_o);
  assert_idle_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_idle_o |-> (!mem_req_o && !m_tvalid_o));
endmodule

// File: tb/sgw_walker_bench.sv
module sgw_walker_bench;
  localparam int AW = 16;
  localparam int NA = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, idle = 1'b0, kick = 1'b0;
  logic [AW-1:0] cur_ptr = '0, tail_ptr = '0;
  logic [AW-1:0] ptr_o;
  logic ptr_we, done, set_idle;
  logic [32*NA-1:0] app;
  logic mreq, mwe, mack;
  logic [AW-1:0] maddr;
  logic [31:0] mwdata, mrdata;
  logic [31:0] tdata;
  logic [3:0] tkeep;
  logic tlast, tvalid;
  logic tready = 1'b1;
  logic stall_mode = 1'b0;

  logic [31:0] mem [256];
  int n_chk = 0, n_fail = 0;
  int beats = 0, dones = 0, idles = 0, both = 0, req_cycles = 0, writes = 0, ptr_wes = 0;
  logic [31:0] b_data [16];
  logic [3:0]  b_keep [16];
  logic        b_last [16];

  always #2.5 clk = ~clk;

  sgw_walker #(.ADDR_W(AW), .NUM_APP(NA)) u_sgw_walker (
    .clk(clk), .rst_n(rst_n), .run_i(run), .idle_i(idle), .kick_i(kick),
    .cur_ptr_i(cur_ptr), .tail_ptr_i(tail_ptr), .cur_ptr_o(ptr_o),
    .cur_ptr_we_o(ptr_we), .done_o(done), .set_idle_o(set_idle), .app_o(app),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .mem_ack_i(mack),
    .m_tdata_o(tdata), .m_tkeep_o(tkeep), .m_tlast_o(tlast),
    .m_tvalid_o(tvalid), .m_tready_i(tready)
  );

  // memory model: one-cycle acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mack <= 1'b0;  mrdata <= '0;
    end else begin
      mack <= 1'b0;
      if (mreq && !mack) begin
        mack <= 1'b1;
        mrdata <= mem[maddr[9:2]];
        if (mwe) mem[maddr[9:2]] <= mwdata;
      end
    end
  end

  // monitor away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (tvalid && tready) begin
        if (beats < 16) begin
          b_data[beats] = tdata;  b_keep[beats] = tkeep;  b_last[beats] = tlast;
        end
        beats++;
      end
      if (done) dones++;
      if (set_idle) idles++;
      if (done && set_idle) both++;
      if (ptr_we) ptr_wes++;
      if (mreq) req_cycles++;
      if (mreq && mwe && mack) writes++;
      tready = stall_mode ? ~tready : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    beats = 0; dones = 0; idles = 0; both = 0; req_cycles = 0; writes = 0; ptr_wes = 0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  task automatic put_desc(input int d, input int bufa, input int nxt, input logic [31:0] ctrl,
                          input logic [31:0] stat, input logic [31:0] app_base);
    mem[d/4 + 0] = bufa;
    mem[d/4 + 2] = nxt;
    mem[d/4 + 4] = ctrl;
    mem[d/4 + 5] = stat;
    for (int i = 0; i < NA; i++) mem[d/4 + 6 + i] = app_base + i;
  endtask

  task automatic start(input int first, input int tail);
    @(negedge clk);
    cur_ptr = AW'(first);  tail_ptr = AW'(tail);  kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 3000 && idles == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!tvalid && !done && !set_idle && !mreq && !ptr_we, "R1 reset outputs",
        {27'b0, tvalid, done, set_idle, mreq, ptr_we}, 32'h0);
  endtask

  task automatic t_gated();
    clear_mem(); clear_counts();
    put_desc(32'h100, 32'h200, 32'h140, 32'h0C00_0004, 32'h0, 32'h0);
    run = 1'b0; idle = 1'b0;
    start(32'h100, 32'h100);
    repeat (20) @(negedge clk);
    chk(req_cycles == 0, "R2 kick while stopped", req_cycles, 0);
    run = 1'b1; idle = 1'b1;
    start(32'h100, 32'h100);
    repeat (20) @(negedge clk);
    chk(req_cycles == 0 && beats == 0, "R2 kick while idle", req_cycles, 0);
    idle = 1'b0;
  endtask

  task automatic t_single();
    clear_mem(); clear_counts();
    // SOF|EOF, length 10
    put_desc(32'h100, 32'h200, 32'h140, 32'h0C00_000A, 32'h0, 32'h5100);
    mem[32'h200/4] = 32'h4433_2211; mem[32'h204/4] = 32'h8877_6655; mem[32'h208/4] = 32'hCCBB_AA99;
    start(32'h100, 32'h100);
    wait_stop();
    chk(beats == 3, "R5 beat count for 10 bytes", beats, 3);
    chk(b_data[0] == 32'h4433_2211 && b_data[2] == 32'hCCBB_AA99, "R3 R5 buffer words in order", b_data[2], 32'hCCBB_AA99);
    chk(b_keep[0] == 4'hF && b_keep[1] == 4'hF, "R6 full keep on inner beats", {b_keep[0], b_keep[1]}, 8'hFF);
    chk(b_keep[2] == 4'b0011, "R6 keep on 2-byte tail", b_keep[2], 4'b0011);
    chk(!b_last[0] && !b_last[1] && b_last[2], "R7 last on final beat", {b_last[0], b_last[1], b_last[2]}, 3'b001);
    chk(mem[32'h114/4] == 32'h8000_000A, "R8 status write-back", mem[32'h114/4], 32'h8000_000A);
    chk(dones == 1 && ptr_wes == 1, "R9 one completion", dones, 1);
    chk(ptr_o == 16'h0140, "R9 pointer advanced", ptr_o, 32'h140);
    chk(both == 1 && idles == 1, "R10 idle with completion at tail", both, 1);
  endtask

  task automatic t_chain();
    clear_mem(); clear_counts();
    put_desc(32'h100, 32'h200, 32'h140, 32'h0800_0004, 32'h0, 32'hA000);
    put_desc(32'h140, 32'h210, 32'h180, 32'h0000_0007, 32'h0, 32'hB000);
    put_desc(32'h180, 32'h220, 32'h1C0, 32'h0400_0001, 32'h0, 32'hC000);
    mem[32'h200/4] = 32'h0101_0101; mem[32'h210/4] = 32'h0202_0202;
    mem[32'h214/4] = 32'h0303_0303; mem[32'h220/4] = 32'h0404_0404;
    stall_mode = 1'b1;
    start(32'h100, 32'h180);
    wait_stop();
    stall_mode = 1'b0;
    chk(beats == 4, "R5 chain beat count", beats, 4);
    chk(b_data[1] == 32'h0202_0202 && b_data[3] == 32'h0404_0404, "R5 chain data under stalls", b_data[3], 32'h0404_0404);
    chk({b_keep[0], b_keep[1], b_keep[2], b_keep[3]} == 16'hFF71, "R6 chain keeps",
        {b_keep[0], b_keep[1], b_keep[2], b_keep[3]}, 16'hFF71);
    chk({b_last[0], b_last[1], b_last[2], b_last[3]} == 4'b0001, "R7 last only at EOF descriptor",
        {b_last[0], b_last[1], b_last[2], b_last[3]}, 4'b0001);
    chk(dones == 3 && ptr_wes == 3, "R9 three completions", dones, 3);
    chk(idles == 1 && both == 1, "R10 single stop at tail", idles, 1);
    chk(ptr_o == 16'h01C0, "R10 pointer after tail", ptr_o, 32'h1C0);
    chk(mem[32'h154/4] == 32'h8000_0007, "R8 middle status", mem[32'h154/4], 32'h8000_0007);
    for (int i = 0; i < NA; i++)
      chk(app[i*32 +: 32] == 32'hA000 + i, "R11 app from SOF descriptor", app[i*32 +: 32], 32'hA000 + i);
  endtask

  task automatic t_complete();
    clear_mem(); clear_counts();
    put_desc(32'h100, 32'h200, 32'h140, 32'h0C00_0008, 32'h8000_0123, 32'h0);
    start(32'h100, 32'h100);
    wait_stop();
    chk(idles == 1, "R4 idle request on completed descriptor", idles, 1);
    chk(beats == 0 && dones == 0 && writes == 0, "R4 no transfer or write", beats + dones + writes, 0);
    chk(mem[32'h114/4] == 32'h8000_0123, "R4 status untouched", mem[32'h114/4], 32'h8000_0123);
  endtask

  task automatic t_zero();
    clear_mem(); clear_counts();
    put_desc(32'h100, 32'h200, 32'h140, 32'h0400_0000, 32'h0, 32'h0);
    start(32'h100, 32'h100);
    wait_stop();
    chk(beats == 0, "R12 zero length sends nothing", beats, 0);
    chk(mem[32'h114/4] == 32'h8000_0000 && dones == 1, "R12 zero length write-back", mem[32'h114/4], 32'h8000_0000);
  endtask

  task automatic t_tail_first();
    clear_mem(); clear_counts();
    put_desc(32'h100, 32'h200, 32'h140, 32'h0C00_0004, 32'h0, 32'h0);
    put_desc(32'h140, 32'h210, 32'h180, 32'h0C00_0004, 32'h0, 32'h0);
    start(32'h100, 32'h100);
    wait_stop();
    chk(dones == 1 && beats == 1, "R10 walk stops at tail", dones, 1);
    chk(mem[32'h154/4] == 32'h0, "R10 descriptor past tail untouched", mem[32'h154/4], 32'h0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_gated();
    run = 1'b1; idle = 1'b0;
    t_single();
    t_chain();
    t_complete();
    t_zero();
    t_tail_first();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule